// File: doc/BRIEF.md
# Connection Memory Block Fill Engine

This block writes one 3-bit code into every word of a 12-bit-wide connection memory. Software raises a start level and supplies the code. The engine then owns the memory write port and walks the addresses from 0 upward, one word per clock. Each word it writes holds the code in its low three bits, and every bit above is zero. When the engine finishes, every channel selects the per-channel tristate output mode. The word layout does this on its own: a word's top two bits choose the per-channel mode (00 tristate, 01 message, 10 error-rate test, 11 reserved), and the fill clears them.

While the sweep runs, the busy output stays high; it is the end flag that software reads back. Busy falls after the last address has been written, and the done output then rises. Software can end a sweep early in two ways. It can pulse the stop input, which is the same as writing the end flag low. It can also drop the start level. After a sweep ends through completion or through stop, the engine does not restart until start has gone low once. Processor accesses share the memory port with the engine and are refused for as long as the sweep runs.

Top module: `cmf_block_fill`

## Requirements
- R1: After reset, busy_o and done_o are 0, cpu_gnt_o is 1, and with no processor request mem_en_o and mem_we_o are 0.
- R2: In idle, a clock edge that samples start_i high begins a sweep. From the next cycle on, busy_o is 1 and one word is written per cycle at addresses 0, 1, 2 and so on. A sweep that is not interrupted keeps busy_o high for exactly DEPTH cycles (2048 by default).
- R3: Each word the sweep writes equals the pattern sampled at start, placed in bits 2:0, with bits 11:3 at zero. A change on pattern_i during the sweep has no effect on the words written.
- R4: When the word at the last address is written, busy_o falls and done_o rises. While start_i stays high after that, no new sweep begins.
- R5: If stop_i is sampled high during a sweep before the last address, the sweep ends after the word of that cycle. The number of words written equals the number of sweep cycles, done_o stays 0, and no new sweep begins until start_i has been low.
- R6: If start_i is sampled low during a sweep, the engine returns to idle with done_o at 0. A later high level on start_i begins a fresh sweep from address 0.
- R7: If stop_i is high in the cycle that writes the last address, completion takes priority: all words are written and done_o rises.
- R8: While busy_o is 1, cpu_gnt_o is 0 and no processor request reaches the memory port.
- R9: Outside a sweep, cpu_gnt_o is 1 and a processor request passes straight through in the same cycle: mem_en_o follows cpu_req_i, mem_we_o equals cpu_req_i AND cpu_we_i, and the address and write data pass through unchanged.
- R10: done_o stays set through idle and is cleared by the edge that begins the next sweep.
- R11: stop_i has no effect outside a sweep. It leaves busy_o, done_o and the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start level from the control register |
| stop_i | input | 1 | Pulse that writes the end flag low |
| pattern_i | input | 3 | Code written into bits 2:0 |
| busy_o | output | 1 | End flag readback, high during the sweep |
| done_o | output | 1 | Sweep ran to the last address |
| cpu_req_i | input | 1 | Processor memory request |
| cpu_we_i | input | 1 | Processor request is a write |
| cpu_addr_i | input | 11 | Processor word address |
| cpu_wdata_i | input | 12 | Processor write data |
| cpu_gnt_o | output | 1 | Processor request accepted this cycle |
| mem_en_o | output | 1 | Memory port enable |
| mem_we_o | output | 1 | Memory port write enable |
| mem_addr_o | output | 11 | Memory port address |
| mem_wdata_o | output | 12 | Memory port write data |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the early stop and the natural end of the sweep. The bench drives stop_i into the cycle that writes the last address, and separately into the cycle just before it. It then checks that the first case ends with done_o set and every word filled, and that the second ends with done_o clear and the last word untouched. The second pair is a processor write and the sweep. The bench holds a write to one address across the start of a sweep, and then confirms that the grant stays low and that the word ends up holding the pattern, not the processor's data.

// File: rtl/cmf_pkg.sv
package cmf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_HOLD = 2'd2
  } cmf_state_e;
endpackage

// File: rtl/cmf_addr_ctr.sv
module cmf_addr_ctr #(
  parameter int ADDR_W = 11,
  parameter int DEPTH  = 2048
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (clr_i)   addr_q <= '0;
    else if (inc_i)   addr_q <= addr_q + 1'b1;
  end

  assign addr_o = addr_q;
  assign last_o = (addr_q == LAST);
endmodule

// File: rtl/cmf_ctrl.sv
module cmf_ctrl
  import cmf_pkg::*;
#(
  parameter int PAT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             last_i,
  input  logic [PAT_W-1:0] pattern_i,
  output logic             fill_o,
  output logic             clr_o,
  output logic             done_o,
  output logic [PAT_W-1:0] pat_o
);
  cmf_state_e        st_q, st_d;
  logic              done_q, done_d;
  logic [PAT_W-1:0]  pat_q;

  always_comb begin
    st_d   = st_q;
    done_d = done_q;
    clr_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d   = ST_FILL;
        clr_o  = 1'b1;
        done_d = 1'b0;
      end
      ST_FILL: begin
        if (!start_i) begin
          st_d = ST_IDLE;
        end else if (last_i) begin
          // completion outranks a coincident stop
          st_d   = ST_HOLD;
          done_d = 1'b1;
        end else if (stop_i) begin
          st_d = ST_HOLD;
        end
      end
      ST_HOLD: if (!start_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      pat_q  <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (clr_o) pat_q <= pattern_i;
    end
  end

  assign fill_o = (st_q == ST_FILL);
  assign done_o = done_q;
  assign pat_o  = pat_q;

  a_r5_stop_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FILL && start_i && stop_i && !last_i) |=> (st_q == ST_HOLD && !done_q));
  a_r6_start_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FILL && !start_i) |=> (st_q == ST_IDLE));
  a_r4_hold_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD && start_i) |=> (st_q == ST_HOLD));
  a_r11_stop_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !start_i) |=> (st_q == ST_IDLE && $stable(done_q)));
endmodule

// File: rtl/cmf_port_mux.sv
module cmf_port_mux #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 12,
  parameter int PAT_W  = 3
) (
  input  logic              fill_i,
  input  logic [ADDR_W-1:0] sweep_addr_i,
  input  logic [PAT_W-1:0]  pat_i,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_gnt_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  localparam int UPPER_W = DATA_W - PAT_W;

  logic [DATA_W-1:0] fill_word;

  generate
    if (UPPER_W > 0) begin : g_pad
      assign fill_word = {{UPPER_W{1'b0}}, pat_i};
    end else begin : g_nopad
      assign fill_word = DATA_W'(pat_i);
    end
  endgenerate

  always_comb begin
    cpu_gnt_o = !fill_i;
    if (fill_i) begin
      mem_en_o    = 1'b1;
      mem_we_o    = 1'b1;
      mem_addr_o  = sweep_addr_i;
      mem_wdata_o = fill_word;
    end else begin
      mem_en_o    = cpu_req_i;
      mem_we_o    = cpu_req_i & cpu_we_i;
      mem_addr_o  = cpu_addr_i;
      mem_wdata_o = cpu_wdata_i;
    end
  end
endmodule

// File: rtl/cmf_block_fill.sv
module cmf_block_fill #(
  parameter int STREAMS  = 16,
  parameter int CHANNELS = 128,
  parameter int DATA_W   = 12,
  parameter int PAT_W    = 3,
  localparam int DEPTH   = STREAMS * CHANNELS,
  localparam int ADDR_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [PAT_W-1:0]  pattern_i,
  output logic              busy_o,
  output logic              done_o,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_gnt_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic              fill, clr, last;
  logic [ADDR_W-1:0] sweep_addr;
  logic [PAT_W-1:0]  pat;

  cmf_ctrl #(.PAT_W(PAT_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .stop_i,
    .last_i    (last),
    .pattern_i,
    .fill_o    (fill),
    .clr_o     (clr),
    .done_o,
    .pat_o     (pat)
  );

  cmf_addr_ctr #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_ctr (
    .clk_i, .rst_ni,
    .clr_i  (clr),
    .inc_i  (fill),
    .addr_o (sweep_addr),
    .last_o (last)
  );

  cmf_port_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAT_W(PAT_W)) u_mux (
    .fill_i       (fill),
    .sweep_addr_i (sweep_addr),
    .pat_i        (pat),
    .cpu_req_i, .cpu_we_i, .cpu_addr_i, .cpu_wdata_i,
    .cpu_gnt_o, .mem_en_o, .mem_we_o, .mem_addr_o, .mem_wdata_o
  );

  assign busy_o = fill;

  a_r2_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> (mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1)));
  a_r2_first_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (mem_addr_o == '0));
  a_r3_pat_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mem_wdata_o));
  a_r4_done_at_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(busy_o) && $past(mem_addr_o) == LAST));
  a_r8_cpu_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!cpu_gnt_o && mem_we_o));
  a_r10_done_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !done_o);
endmodule

// File: tb/cmf_block_fill_tb.sv
module cmf_block_fill_tb;
  localparam int CLK_P  = 10;
  localparam int DEPTH  = 2048;
  localparam int AW     = 11;
  localparam int DW     = 12;
  localparam int NVEC   = 5;
  localparam logic [DW-1:0] BG = 12'hFFF;
  // stop_at 0: no stop; k: stop sampled at the k-th sweep edge
  localparam logic [2:0] VPAT  [NVEC] = '{3'b101, 3'b010, 3'b000, 3'b011, 3'b111};
  localparam int         VSTOP [NVEC] = '{0, 5, 1, 2047, 2048};

  logic clk = 0, rst_n = 0;
  logic start = 0, stop = 0;
  logic [2:0] pattern = '0;
  logic busy, done;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_gnt, mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic clr_mem = 0;
  logic [DW-1:0] bmem [DEPTH];
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    if (clr_mem) begin
      for (int i = 0; i < DEPTH; i++) bmem[i] <= BG;
    end else if (mem_we) begin
      bmem[mem_addr] <= mem_wdata;
    end
  end

  cmf_block_fill u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .pattern_i(pattern), .busy_o(busy), .done_o(done),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_gnt_o(cpu_gnt), .mem_en_o(mem_en),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    @(negedge clk) clr_mem = 1;
    @(negedge clk) clr_mem = 0;
  endtask

  task automatic scan(input logic [2:0] p, input int cnt, input string req);
    int miss = 0;
    int first = -1;
    for (int i = 0; i < DEPTH; i++) begin
      logic [DW-1:0] e;
      e = (i < cnt) ? {9'b0, p} : BG;
      if (bmem[i] !== e) begin
        miss++;
        if (first < 0) first = i;
      end
    end
    chk(miss == 0, req, first, cnt);
  endtask

  task automatic run_vec(input logic [2:0] p, input int k);
    int n = 0;
    int cnt;
    clear_mem();
    pattern = p;
    start = 1;
    @(posedge clk);
    if (k == 0) begin
      @(negedge clk);
      while (busy && n < 5000) begin n++; @(negedge clk); end
      chk(n == DEPTH, "R2 sweep length", n, DEPTH);
    end else begin
      repeat (k - 1) @(posedge clk);
      @(negedge clk) stop = 1;
      @(posedge clk);
      @(negedge clk) stop = 0;
    end
    cnt = (k == 0) ? DEPTH : k;
    chk(busy == 0, "R5/R7 busy after end", busy, 0);
    chk(done == (cnt == DEPTH), (cnt == DEPTH) ? "R4/R7 done set" : "R5 done clear",
        done, cnt == DEPTH);
    repeat (3) @(negedge clk);
    chk(busy == 0, "R4/R5 no restart while start high", busy, 0);
    start = 0;
    @(negedge clk);
    scan(p, cnt, "R3 word contents");
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0, "R1 status", {busy, done}, 0);
    chk(cpu_gnt == 1 && mem_en == 0 && mem_we == 0, "R1 port", {cpu_gnt, mem_en, mem_we}, 3'b100);

    // R9 pass-through outside sweep
    clear_mem();
    cpu_req = 1; cpu_we = 1; cpu_addr = 11'd9; cpu_wdata = 12'h5A5;
    #1;
    chk(cpu_gnt && mem_en && mem_we && mem_addr == 11'd9 && mem_wdata == 12'h5A5,
        "R9 pass-through", {mem_addr, mem_wdata}, {11'd9, 12'h5A5});
    @(negedge clk);
    cpu_we = 0;
    #1;
    chk(mem_en == 1 && mem_we == 0, "R9 read request", {mem_en, mem_we}, 2'b10);
    cpu_req = 0;
    chk(bmem[9] == 12'h5A5, "R9 write landed", bmem[9], 12'h5A5);

    // table-driven fills
    for (int v = 0; v < NVEC; v++) run_vec(VPAT[v], VSTOP[v]);

    // R11: stop outside sweep ignored (done still set from last vector)
    @(negedge clk) stop = 1;
    repeat (2) @(negedge clk);
    stop = 0;
    chk(busy == 0 && done == 1, "R11 stop in idle", {busy, done}, 2'b01);
    chk(bmem[0] == 12'h007 && bmem[DEPTH-1] == 12'h007, "R11 memory kept", bmem[0], 12'h007);

    // R10 + R8 + R3 latch: new sweep with held processor write and pattern change
    clear_mem();
    pattern = 3'b110; start = 1;
    cpu_req = 1; cpu_we = 1; cpu_addr = 11'd7; cpu_wdata = 12'hABC;
    @(posedge clk);
    @(negedge clk);
    chk(busy == 1 && done == 0, "R10 done cleared at start", {busy, done}, 2'b10);
    chk(cpu_gnt == 0 && mem_wdata == 12'h006, "R8 cpu held off", {cpu_gnt, mem_wdata}, 12'h006);
    repeat (50) @(negedge clk);
    pattern = 3'b001;
    repeat (50) @(negedge clk);
    cpu_req = 0;
    begin
      int n = 0;
      while (busy && n < 5000) begin n++; @(negedge clk); end
    end
    chk(done == 1, "R4 done after full sweep", done, 1);
    chk(bmem[7] == 12'h006, "R8 cpu write blocked", bmem[7], 12'h006);
    chk(bmem[DEPTH-1] == 12'h006, "R3 pattern latched", bmem[DEPTH-1], 12'h006);
    start = 0;
    @(negedge clk);

    // R6: start dropped mid-sweep, then immediate restart
    clear_mem();
    pattern = 3'b100; start = 1;
    @(posedge clk);
    repeat (9) @(posedge clk);
    @(negedge clk) start = 0;
    @(posedge clk);
    @(negedge clk);
    chk(busy == 0 && done == 0, "R6 return to idle", {busy, done}, 0);
    scan(3'b100, 10, "R6 partial words");
    start = 1;
    @(posedge clk);
    @(negedge clk);
    chk(busy == 1 && mem_addr == 0, "R6 restart from zero", mem_addr, 0);
    begin
      int n = 1;
      while (busy && n < 5000) begin n++; @(negedge clk); end
      chk(n == DEPTH + 1, "R2 restart sweep length", n - 1, DEPTH);
    end
    start = 0;
    @(negedge clk);
    scan(3'b100, DEPTH, "R6 full refill");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule